// File: doc/BRIEF.md
# Multi-Thread Retire Slot Selector

In a core that interleaves several hardware threads, each commit slot retires the oldest reorder-buffer entry of one thread. This block decides which thread owns the current slot. For every thread it receives a commit status code, a flag that the thread's reorder buffer is empty, a flag that the head entry is ready, and the head entry's sequence number. From these it returns a valid bit and a thread index. The answer is purely combinational, so a retire loop can ask again within the same cycle after it updates the head information.

A static policy input picks the arbitration scheme:
- **Rotating:** walks a priority list from front to back. When the surrounding logic confirms a pick on a clock edge, the winner moves to the tail of the list.
- **Oldest:** picks the thread whose head has the smallest sequence number.
- **Greedy:** uses the same comparison as the oldest scheme. The caller simply invokes it for every slot of a cycle.

Threads that are trapping or squashing are never chosen. When only one thread is built, all arbitration is bypassed.

Top module: `commit_thread_sel`

## Requirements
- R1: Status codes are 3 bits per thread. The codes 0 (idle), 1 (running) and 2 (fetch trap pending) are eligible. The codes 3 (trap pending) and 4 (squashing) are never selected, and neither are the unused codes 5 to 7.
- R2: With more than one thread, a thread is a candidate only when it is eligible, its rob_empty bit is 0 and its head_ready bit is 1. A selected thread is always a candidate.
- R3: With policy code 2 (oldest), the selector returns the candidate with the smallest head sequence number, compared as an unsigned value.
- R4: Under the oldest comparison, equal sequence numbers resolve to the lower thread index.
- R5: Policy code 0 (greedy) and the spare code 3 select exactly as the oldest policy does.
- R6: With policy code 1 (rotating), the selector returns the first candidate found while walking the priority list from front to tail.
- R7: After reset the priority list holds the thread indices in ascending order, with thread 0 at the front.
- R8: When commit_i is 1 at a rising clock edge under the rotating policy with a valid selection, the selected thread moves to the tail of the list. The other threads keep their relative order.
- R9: commit_i leaves the priority list unchanged when no selection is valid or when the policy is not rotating.
- R10: When no thread is a candidate, sel_valid_o is 0 and sel_tid_o is 0.
- R11: With one thread built, sel_valid_o equals the eligibility of that thread's status, regardless of its empty and ready flags, and sel_tid_o is 0.
- R12: The outputs follow the inputs within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| policy_i | input | 2 | Arbitration policy code |
| status_i | input | NT*3 | Per-thread commit status; thread i occupies bits [3i+2:3i] |
| rob_empty_i | input | NT | Per-thread reorder buffer empty flag |
| head_ready_i | input | NT | Per-thread head entry ready flag |
| head_seq_i | input | NT*SEQ_W | Per-thread head sequence number; thread i occupies bits [SEQ_W*i +: SEQ_W] |
| commit_i | input | 1 | Edge strobe confirming that the current selection was used |
| sel_valid_o | output | 1 | A thread is selected |
| sel_tid_o | output | TID_W | Selected thread index |

## Verification
The bench builds one instance with four threads and 32-bit sequence numbers, and a second instance with a single thread.

The four-thread instance is driven through several thousand mixed vectors:
- Sequence numbers are drawn mostly from a tiny range, so that ties and lowest-index tie-breaks occur often.
- Some sequence numbers have the top bit set, so that the comparison is exercised as unsigned.
- Policy codes are mixed, and confirm strobes are scattered, so that the rotating list visits many permutations. A bench-side list model predicts every one of them.

The single-thread instance is swept over all status codes and flag combinations, which makes the bypass path exhaustive.

// File: rtl/commit_sel_pkg.sv
package commit_sel_pkg;
  localparam int ST_W = 3;

  typedef enum logic [ST_W-1:0] {
    CS_IDLE       = 3'd0,
    CS_RUNNING    = 3'd1,
    CS_FETCH_TRAP = 3'd2,
    CS_TRAP       = 3'd3,
    CS_SQUASHING  = 3'd4
  } cstat_e;

  typedef enum logic [1:0] {
    POL_GREEDY = 2'd0,
    POL_ROTATE = 2'd1,
    POL_OLDEST = 2'd2,
    POL_SPARE  = 2'd3
  } policy_e;

  // Status whitelist: only these states may retire.
  function automatic logic may_commit(logic [ST_W-1:0] s);
    return (s == CS_IDLE) || (s == CS_RUNNING) || (s == CS_FETCH_TRAP);
  endfunction

  // Unsigned "a strictly older than b".
  function automatic logic seq_older(logic [63:0] a, logic [63:0] b);
    return a < b;
  endfunction
endpackage

// File: rtl/thread_qualify.sv
module thread_qualify
  import commit_sel_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic [NT*ST_W-1:0] status_i,
  input  logic [NT-1:0]      rob_empty_i,
  input  logic [NT-1:0]      head_ready_i,
  output logic [NT-1:0]      elig_o,
  output logic [NT-1:0]      cand_o
);
  for (genvar i = 0; i < NT; i++) begin : g_thr
    assign elig_o[i] = may_commit(status_i[i*ST_W +: ST_W]);
    assign cand_o[i] = elig_o[i] & head_ready_i[i] & ~rob_empty_i[i];
  end
endmodule

// File: rtl/oldest_pick.sv
module oldest_pick
  import commit_sel_pkg::*;
#(
  parameter int NT    = 4,
  parameter int SEQ_W = 32,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NT-1:0]       cand_i,
  input  logic [NT*SEQ_W-1:0] seq_i,
  output logic                valid_o,
  output logic [TID_W-1:0]    tid_o
);
  logic [SEQ_W-1:0] best_seq;

  // Compare against the best sequence seen so far; strict less-than
  // keeps the lower index on ties.
  always_comb begin
    valid_o  = 1'b0;
    tid_o    = '0;
    best_seq = '0;
    for (int i = 0; i < NT; i++) begin
      if (cand_i[i] && (!valid_o ||
          seq_older(64'(seq_i[i*SEQ_W +: SEQ_W]), 64'(best_seq)))) begin
        valid_o  = 1'b1;
        tid_o    = TID_W'(i);
        best_seq = seq_i[i*SEQ_W +: SEQ_W];
      end
    end
  end

  // R3
  oldest_is_cand_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cand_i[tid_o]);
  // R10
  oldest_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_i == '0) |-> !valid_o);
endmodule

// File: rtl/rotate_pick.sv
module rotate_pick #(
  parameter int NT = 4,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NT-1:0]    cand_i,
  input  logic             upd_en_i,
  output logic             valid_o,
  output logic [TID_W-1:0] tid_o
);
  logic [TID_W-1:0] prio_q [NT];
  logic [TID_W-1:0] win_pos;
  logic [NT-1:0]    present;

  always_comb begin
    valid_o = 1'b0;
    tid_o   = '0;
    win_pos = '0;
    for (int p = 0; p < NT; p++) begin
      if (!valid_o && cand_i[prio_q[p]]) begin
        valid_o = 1'b1;
        tid_o   = prio_q[p];
        win_pos = TID_W'(p);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NT; p++) prio_q[p] <= TID_W'(p);
    end else if (upd_en_i) begin
      for (int p = 0; p < NT - 1; p++)
        if (TID_W'(p) >= win_pos) prio_q[p] <= prio_q[p+1];
      prio_q[NT-1] <= tid_o;
    end
  end

  always_comb begin
    present = '0;
    for (int p = 0; p < NT; p++) present[prio_q[p]] = 1'b1;
  end

  // R8
  list_is_perm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(present) == NT);
  // R8
  winner_to_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> prio_q[NT-1] == $past(tid_o));
endmodule

// File: rtl/commit_thread_sel.sv
module commit_thread_sel
  import commit_sel_pkg::*;
#(
  parameter int NT    = 4,
  parameter int SEQ_W = 32,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          policy_i,
  input  logic [NT*ST_W-1:0]  status_i,
  input  logic [NT-1:0]       rob_empty_i,
  input  logic [NT-1:0]       head_ready_i,
  input  logic [NT*SEQ_W-1:0] head_seq_i,
  input  logic                commit_i,
  output logic                sel_valid_o,
  output logic [TID_W-1:0]    sel_tid_o
);
  logic [NT-1:0] elig, cand;

  thread_qualify #(.NT(NT)) u_qual (
    .status_i(status_i), .rob_empty_i(rob_empty_i),
    .head_ready_i(head_ready_i), .elig_o(elig), .cand_o(cand)
  );

  if (NT == 1) begin : g_single
    assign sel_valid_o = elig[0];
    assign sel_tid_o   = '0;
  end else begin : g_multi
    logic             use_rot, upd_en;
    logic             rot_valid, old_valid;
    logic [TID_W-1:0] rot_tid, old_tid;

    assign use_rot = (policy_i == POL_ROTATE);
    assign upd_en  = commit_i & use_rot & rot_valid;

    rotate_pick #(.NT(NT)) u_rot (
      .clk_i(clk_i), .rst_ni(rst_ni), .cand_i(cand),
      .upd_en_i(upd_en), .valid_o(rot_valid), .tid_o(rot_tid)
    );

    oldest_pick #(.NT(NT), .SEQ_W(SEQ_W)) u_old (
      .clk_i(clk_i), .rst_ni(rst_ni), .cand_i(cand), .seq_i(head_seq_i),
      .valid_o(old_valid), .tid_o(old_tid)
    );

    assign sel_valid_o = use_rot ? rot_valid : old_valid;
    assign sel_tid_o   = use_rot ? rot_tid   : old_tid;

    // R2
    sel_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sel_valid_o |-> (head_ready_i[sel_tid_o] && !rob_empty_i[sel_tid_o]));
  end

  // R1
  sel_whitelist_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_valid_o |-> (status_i[sel_tid_o*ST_W +: ST_W] < 3'd3));
  // R10
  idle_tid_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_valid_o |-> (sel_tid_o == '0));
endmodule

// File: tb/commit_thread_sel_test.sv
`timescale 1ns/1ps
module commit_thread_sel_test;
  localparam int NT = 4;
  localparam int SW = 32;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [1:0]       policy;
  logic [NT*3-1:0]  status;
  logic [NT-1:0]    empty, ready;
  logic [NT*SW-1:0] seq;
  logic             commit;
  logic             valid;
  logic [1:0]       tid;

  logic [2:0] s1_status;
  logic       s1_empty, s1_ready, s1_valid;
  logic [0:0] s1_tid;

  commit_thread_sel #(.NT(NT), .SEQ_W(SW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .status_i(status),
    .rob_empty_i(empty), .head_ready_i(ready), .head_seq_i(seq),
    .commit_i(commit), .sel_valid_o(valid), .sel_tid_o(tid)
  );

  commit_thread_sel #(.NT(1), .SEQ_W(SW)) uut_one (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(2'd1), .status_i(s1_status),
    .rob_empty_i(s1_empty), .head_ready_i(s1_ready), .head_seq_i(32'd5),
    .commit_i(1'b1), .sel_valid_o(s1_valid), .sel_tid_o(s1_tid)
  );

  int nvec = 0, nfail = 0;
  int mlist[NT];
  bit finished = 0;

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_cand(int i);
    return (status[i*3 +: 3] <= 3'd2) && ready[i] && !empty[i];
  endfunction

  // Apply one vector at negedge, check, optionally confirm at posedge.
  task automatic apply(string req, bit do_commit);
    bit ev; int et; int pos;
    logic [SW-1:0] mn;
    @(negedge clk);
    commit = do_commit;
    #1;
    ev = 0; et = 0; pos = 0;
    if (policy == 2'd1) begin
      for (int p = NT - 1; p >= 0; p--)
        if (is_cand(mlist[p])) begin ev = 1; et = mlist[p]; pos = p; end
    end else begin
      mn = '1;
      for (int i = 0; i < NT; i++)
        if (is_cand(i)) begin ev = 1; if (seq[i*SW +: SW] < mn) mn = seq[i*SW +: SW]; end
      for (int i = NT - 1; i >= 0; i--)
        if (is_cand(i) && seq[i*SW +: SW] == mn) et = i;
    end
    chk({req, " valid"}, int'(valid), int'(ev));
    chk({req, " tid"}, int'(tid), et);
    if (do_commit && ev && policy == 2'd1) begin
      for (int p = pos; p < NT - 1; p++) mlist[p] = mlist[p+1];
      mlist[NT-1] = et;
    end
    @(posedge clk);
    #0.1 commit = 0;
  endtask

  task automatic all_ready(logic [1:0] pol);
    policy = pol;
    status = {4{3'd1}};
    empty = '0;
    ready = '1;
    seq = {32'd9, 32'd9, 32'd9, 32'd9};
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    for (int p = 0; p < NT; p++) mlist[p] = p;
    commit = 0;
    all_ready(2'd1);
    s1_status = 0; s1_empty = 0; s1_ready = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R7 R6 R8: reset order, then rotation through the list
    apply("R7 reset order", 1);
    for (int k = 0; k < 5; k++) apply("R8 rotate", 1);

    // R9: confirm under the oldest policy must not move the list
    all_ready(2'd2);
    seq[2*SW +: SW] = 32'd1;
    apply("R9 oldest commit", 1);
    all_ready(2'd1);
    apply("R9 list kept", 0);

    // R9: confirm with no candidate
    ready = '0;
    apply("R9 R10 none", 1);
    ready = '1;
    apply("R9 list kept2", 0);

    // R4: all equal sequence numbers go to the lowest index
    all_ready(2'd2);
    apply("R4 tie", 0);

    // R3: unsigned compare
    seq = {32'h8000_0000, 32'h7fff_ffff, 32'hffff_ffff, 32'h9000_0000};
    apply("R3 unsigned", 0);

    // R1: trap and squash states are never selected
    status = {3'd3, 3'd4, 3'd7, 3'd0};
    seq = {32'd0, 32'd0, 32'd0, 32'd50};
    apply("R1 whitelist", 0);

    // R5: spare and greedy codes
    policy = 2'd3;
    apply("R5 spare", 0);
    policy = 2'd0;
    apply("R5 greedy", 0);

    // R2 R3 R4 R5 R6 R8 R10 R12: mixed sweep
    for (int v = 0; v < 4000; v++) begin
      policy = 2'($urandom % 4);
      for (int i = 0; i < NT; i++) begin
        status[i*3 +: 3] = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'($urandom % 3);
        empty[i] = ($urandom % 5 == 0);
        ready[i] = ($urandom % 4 != 0);
        seq[i*SW +: SW] = ($urandom % 3 == 0) ? $urandom : 32'($urandom % 6);
      end
      apply("R2 R3 R6 R12 sweep", 1'($urandom % 2));
    end

    // R11: single-thread bypass, exhaustive
    for (int s = 0; s < 8; s++)
      for (int f = 0; f < 4; f++) begin
        @(negedge clk);
        s1_status = 3'(s);
        s1_empty = f[0];
        s1_ready = f[1];
        #1;
        chk("R11 single valid", int'(s1_valid), int'(s <= 2));
        chk("R11 single tid", int'(s1_tid), 0);
      end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule